// File: doc/BRIEF.md
# IR Wake-Up Pattern Matcher

This block watches a demodulated consumer-infrared receive line and raises a wake request when a programmed message arrives. A programmable cell timer samples the line once per cell time. From the first active cell onward, every sampled cell is shifted into an 88-cell history. When the number of cells needed by the selected protocol has arrived, the history is compared with an 11-byte compare pattern. An 11-byte mask limits the comparison, so that a mask bit of 0 removes that cell from it (for example a toggle cell).

Software programs the block through a byte-wide register port. It selects a protocol, enables and optionally inverts the receiver, and sets the cell time and the compare length used by the Manchester-cell protocol. It loads the compare and mask bytes through an index/data register pair whose address advances on each data write. Four status flags record match, message end, buffer full and short repeat bursts. A flag is cleared by writing 1 to it. A per-event enable decides which flags drive the wake output.

Top module: `ir_wake_matcher`

Register offsets: 0x3 control, 0x4 status, 0x5 event enable, 0x8 index, 0x9 data, 0xA compare length, 0xB cell time, 0xC spare configuration. Unused offsets read 0.

## Requirements
- R1: After reset every register reads 0 except the cell-time register, which reads 0x4A, and `wake` is 0.
- R2: The index register holds a 2-bit array select in bits 5:4 (01 compare, 10 mask) and a start byte in bits 3:0, and it reads back as written. Each data write stores the byte into the selected array at the current byte and advances the byte by one. Byte address 11 and above ignores writes and does not advance. A data read returns the selected byte (0 when the select is not 01 or 10, or when the address is 11 or more) and does not advance.
- R3: The line is sampled once every cell-time + 1 clocks (cell time in bits 6:0 of 0xB), through a two-stage synchronizer. A message starts at the first sampled 1. Each sampled cell enters bit 0 of the history and older cells move up, so compare byte k covers history bits 8k+7:8k.
- R4: Control bits 5:4 set the compare length: 0 gives 14 cells, 1 gives 32 cells, 2 uses the compare-length register (Manchester cells, a data 1 sent as cells 1 then 0), and 3 disables comparison.
- R5: When the cell count of a message reaches the compare length, status bit 0 (match) is set if ((history XOR compare) AND mask) is zero. Cells whose mask bit is 0 never block a match.
- R6: Control bit 3 inverts the receive line before sampling.
- R7: Nine consecutive 0 cells inside a message end it. This sets status bit 1 (message end) and clears the history and the cell count for the next message.
- R8: Status bit 2 (buffer) is set when one message reaches 88 cells. The cell count stops at 88.
- R9: In protocol 1, a message that ends before reaching 32 cells sets status bit 4 (repeat).
- R10: Writing status clears each flag written as 1 and leaves flags written as 0. A flag being set in the same cycle stays set.
- R11: `wake` is 1 exactly when control bit 0 is 1 and some status flag among bits 2:0 has its event-enable bit (same position in 0x5) set.
- R12: With control bit 0 cleared, the cell timer stops, message state is cleared, and line activity sets no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| rx_in | input | 1 | Demodulated receive line |
| wake | output | 1 | Wake request |

## Verification
The assertions take several things for granted. Writes arrive as single-cycle strobes. The receive line is a level that holds for whole cell times, so a rising match flag can always be traced to a completed compare, and message state is empty whenever the receiver is off. The stimulus drives each cell for exactly cell-time + 1 clocks and never places nine 0 cells inside a pattern. It flips the inversion bit only while the receiver is disabled, so that a change of polarity can never start a false message.

// File: rtl/ir_wake_pkg.sv
package ir_wake_pkg;
  localparam logic [3:0] OFS_CTRL  = 4'h3;
  localparam logic [3:0] OFS_STAT  = 4'h4;
  localparam logic [3:0] OFS_EVEN  = 4'h5;
  localparam logic [3:0] OFS_INDEX = 4'h8;
  localparam logic [3:0] OFS_DATA  = 4'h9;
  localparam logic [3:0] OFS_CLEN  = 4'hA;
  localparam logic [3:0] OFS_CELL  = 4'hB;
  localparam logic [3:0] OFS_SPARE = 4'hC;

  typedef enum logic [1:0] {
    PROTO_BIPHASE = 2'd0,
    PROTO_PULSE   = 2'd1,
    PROTO_MCELL   = 2'd2,
    PROTO_OFF     = 2'd3
  } proto_e;
endpackage

// File: rtl/ir_cell_timer.sv
module ir_cell_timer #(
  parameter int TW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          tick
);
  logic [TW-1:0] div_q, div_d;

  assign tick = run && (div_q == limit);

  always_comb begin
    div_d = div_q + TW'(1);
    if (!run || tick) div_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/ir_cell_shifter.sv
module ir_cell_shifter #(
  parameter int NBITS      = 88,
  parameter int IDLE_CELLS = 8,
  parameter int LW         = 8,
  localparam int CW = $clog2(NBITS + 1),
  localparam int IW = $clog2(IDLE_CELLS + 1),
  localparam int XW = ((CW > LW) ? CW : LW) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             lvl,
  input  logic [LW-1:0]    len,
  input  logic             len_ok,
  output logic [NBITS-1:0] hist_o,
  output logic [CW-1:0]    cnt_o,
  output logic             busy_o,
  output logic             go_o,
  output logic             end_o,
  output logic             full_o,
  output logic             short_o
);
  logic [NBITS-1:0] sh_q, sh_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [IW-1:0]    idle_q, idle_d;
  logic             busy_q, busy_d, hit_q, hit_d;
  logic             go_q, go_d, end_q, end_d, full_q, full_d, short_q, short_d;
  logic             at_len;

  assign at_len = len_ok && ((XW'(cnt_q) + XW'(1)) == XW'(len))
                  && (cnt_q != CW'(NBITS));

  always_comb begin
    sh_d = sh_q; cnt_d = cnt_q; idle_d = idle_q; busy_d = busy_q; hit_d = hit_q;
    go_d = 1'b0; end_d = 1'b0; full_d = 1'b0; short_d = 1'b0;
    if (!run) begin
      sh_d = '0; cnt_d = '0; idle_d = '0; busy_d = 1'b0; hit_d = 1'b0;
    end else if (tick) begin
      if (!busy_q) begin
        if (lvl) begin
          sh_d   = NBITS'(1);
          cnt_d  = CW'(1);
          idle_d = '0;
          busy_d = 1'b1;
          hit_d  = at_len;
          go_d   = at_len;
        end
      end else if (!lvl && (idle_q == IW'(IDLE_CELLS))) begin
        end_d   = 1'b1;
        short_d = !hit_q;
        sh_d = '0; cnt_d = '0; idle_d = '0; busy_d = 1'b0; hit_d = 1'b0;
      end else begin
        sh_d   = {sh_q[NBITS-2:0], lvl};
        idle_d = lvl ? '0 : idle_q + IW'(1);
        if (cnt_q != CW'(NBITS)) cnt_d = cnt_q + CW'(1);
        full_d = (cnt_q == CW'(NBITS - 1));
        if (at_len) begin
          go_d  = 1'b1;
          hit_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; cnt_q <= '0; idle_q <= '0; busy_q <= 1'b0; hit_q <= 1'b0;
      go_q <= 1'b0; end_q <= 1'b0; full_q <= 1'b0; short_q <= 1'b0;
    end else begin
      sh_q <= sh_d; cnt_q <= cnt_d; idle_q <= idle_d; busy_q <= busy_d; hit_q <= hit_d;
      go_q <= go_d; end_q <= end_d; full_q <= full_d; short_q <= short_d;
    end
  end

  assign hist_o  = sh_q;
  assign cnt_o   = cnt_q;
  assign busy_o  = busy_q;
  assign go_o    = go_q;
  assign end_o   = end_q;
  assign full_o  = full_q;
  assign short_o = short_q;
endmodule

// File: rtl/ir_pattern_bank.sv
module ir_pattern_bank #(
  parameter int NBYTES = 11,
  parameter int DW     = 8,
  parameter int AW     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 idx_we,
  input  logic                 dat_we,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        idx_o,
  output logic [DW-1:0]        dat_o,
  output logic [NBYTES*DW-1:0] cmp_o,
  output logic [NBYTES*DW-1:0] msk_o
);
  logic [1:0]    sel_q, sel_d;
  logic [AW-1:0] adr_q, adr_d;
  logic          adr_ok;
  logic [DW-1:0] cmp_q [NBYTES];
  logic [DW-1:0] msk_q [NBYTES];

  assign adr_ok = (int'(adr_q) < NBYTES);
  assign idx_o  = DW'({sel_q, adr_q});

  always_comb begin
    sel_d = sel_q;
    adr_d = adr_q;
    if (idx_we) begin
      sel_d = wdata[AW+1:AW];
      adr_d = wdata[AW-1:0];
    end else if (dat_we && adr_ok) begin
      adr_d = adr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      adr_q <= '0;
    end else begin
      sel_q <= sel_d;
      adr_q <= adr_d;
    end
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic we_cmp, we_msk;
    assign we_cmp = dat_we && (int'(adr_q) == i) && (sel_q == 2'b01);
    assign we_msk = dat_we && (int'(adr_q) == i) && (sel_q == 2'b10);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmp_q[i] <= '0;
      else if (we_cmp) cmp_q[i] <= wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      msk_q[i] <= '0;
      else if (we_msk) msk_q[i] <= wdata;
    end
    assign cmp_o[i*DW +: DW] = cmp_q[i];
    assign msk_o[i*DW +: DW] = msk_q[i];
  end

  always_comb begin
    dat_o = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (adr_ok && int'(adr_q) == i) begin
        if (sel_q == 2'b01) dat_o = cmp_q[i];
        if (sel_q == 2'b10) dat_o = msk_q[i];
      end
    end
  end
endmodule

// File: rtl/ir_wake_matcher.sv
module ir_wake_matcher #(
  parameter int         NBYTES        = 11,
  parameter int         DW            = 8,
  parameter int         IDLE_CELLS    = 8,
  parameter int         BIPHASE_CELLS = 14,
  parameter int         PULSE_CELLS   = 32,
  parameter logic [6:0] CELL_RESET    = 7'h4A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          rx_in,
  output logic          wake
);
  import ir_wake_pkg::*;
  localparam int NBITS = NBYTES * DW;
  localparam int CW    = $clog2(NBITS + 1);

  logic [DW-1:0] ctrl_q, ctrl_d, clen_q, clen_d, spare_q, spare_d;
  logic [2:0]    even_q, even_d;
  logic [6:0]    cell_q, cell_d;
  logic [4:0]    st_q, st_d, st_set, st_clr;
  logic [1:0]    sync_q;
  logic          ctrl_en, lvl, tick, len_ok;
  logic [DW-1:0] len_sel;
  proto_e        proto;
  logic [NBITS-1:0] hist, cmp_vec, msk_vec;
  logic [CW-1:0]    cell_cnt;
  logic          busy, cmp_go, end_pls, full_pls, short_pls, set_match;
  logic [DW-1:0] idx_rd, dat_rd;

  assign ctrl_en = ctrl_q[0];
  assign proto   = proto_e'(ctrl_q[5:4]);
  assign lvl     = sync_q[1] ^ ctrl_q[3];

  always_comb begin
    len_ok  = 1'b1;
    len_sel = clen_q;
    case (proto)
      PROTO_BIPHASE: len_sel = DW'(BIPHASE_CELLS);
      PROTO_PULSE:   len_sel = DW'(PULSE_CELLS);
      PROTO_MCELL:   len_sel = clen_q;
      default:       len_ok  = 1'b0;
    endcase
  end

  ir_cell_timer #(.TW(7)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(ctrl_en), .limit(cell_q), .tick(tick)
  );

  ir_cell_shifter #(.NBITS(NBITS), .IDLE_CELLS(IDLE_CELLS), .LW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .run(ctrl_en), .tick(tick), .lvl(lvl),
    .len(len_sel), .len_ok(len_ok), .hist_o(hist), .cnt_o(cell_cnt),
    .busy_o(busy), .go_o(cmp_go), .end_o(end_pls), .full_o(full_pls),
    .short_o(short_pls)
  );

  ir_pattern_bank #(.NBYTES(NBYTES), .DW(DW), .AW(4)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .idx_we(reg_wr && reg_addr == OFS_INDEX),
    .dat_we(reg_wr && reg_addr == OFS_DATA),
    .wdata(reg_wdata), .idx_o(idx_rd), .dat_o(dat_rd),
    .cmp_o(cmp_vec), .msk_o(msk_vec)
  );

  assign set_match = cmp_go && ((hist ^ cmp_vec) & msk_vec) == '0;

  always_comb begin
    st_set = {short_pls && (proto == PROTO_PULSE), 1'b0, full_pls, end_pls, set_match};
    st_clr = (reg_wr && reg_addr == OFS_STAT) ? reg_wdata[4:0] : 5'd0;
    st_d   = ((st_q & ~st_clr) | st_set) & 5'b10111;
    ctrl_d = ctrl_q; even_d = even_q; clen_d = clen_q; cell_d = cell_q; spare_d = spare_q;
    if (reg_wr) begin
      case (reg_addr)
        OFS_CTRL:  ctrl_d  = reg_wdata & 8'h39;
        OFS_EVEN:  even_d  = reg_wdata[2:0];
        OFS_CLEN:  clen_d  = reg_wdata;
        OFS_CELL:  cell_d  = reg_wdata[6:0];
        OFS_SPARE: spare_d = reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; even_q <= '0; clen_q <= '0; cell_q <= CELL_RESET;
      spare_q <= '0; st_q <= '0; sync_q <= '0;
    end else begin
      ctrl_q <= ctrl_d; even_q <= even_d; clen_q <= clen_d; cell_q <= cell_d;
      spare_q <= spare_d; st_q <= st_d; sync_q <= {sync_q[0], rx_in};
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_CTRL:  reg_rdata = ctrl_q;
      OFS_STAT:  reg_rdata = DW'(st_q);
      OFS_EVEN:  reg_rdata = DW'(even_q);
      OFS_INDEX: reg_rdata = idx_rd;
      OFS_DATA:  reg_rdata = dat_rd;
      OFS_CLEN:  reg_rdata = clen_q;
      OFS_CELL:  reg_rdata = DW'(cell_q);
      OFS_SPARE: reg_rdata = spare_q;
      default:   reg_rdata = '0;
    endcase
  end

  assign wake = ctrl_en && |(st_q[2:0] & even_q);
endmodule

// File: rtl/ir_wake_chk.sv
module ir_wake_chk #(
  parameter int NBITS = 88,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctrl_en,
  input logic          wake,
  input logic          busy,
  input logic [CW-1:0] cell_cnt,
  input logic          cmp_go,
  input logic          end_pls,
  input logic          set_match,
  input logic          st_match,
  input logic          reg_wr,
  input logic [3:0]    reg_addr,
  input logic [7:0]    reg_wdata
);
  AST_WAKE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> ctrl_en); // R11
  AST_OFF_CLEARS_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> !busy); // R12
  AST_MATCH_FROM_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_match) |-> $past(cmp_go)); // R5
  AST_MATCH_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'h4 && reg_wdata[0] && !set_match) |=> !st_match); // R10
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cell_cnt) <= NBITS); // R8
  AST_END_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    end_pls |-> (cell_cnt == '0 && !busy)); // R7
endmodule

bind ir_wake_matcher ir_wake_chk #(.NBITS(NBITS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .wake(wake), .busy(busy),
  .cell_cnt(cell_cnt), .cmp_go(cmp_go), .end_pls(end_pls),
  .set_match(set_match), .st_match(st_q[0]), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/tb_ir_wake_matcher.sv
`timescale 1ns/1ps
module tb_ir_wake_matcher;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       rx_in = 1'b0;
  logic       wake;
  int checks = 0;
  int errors = 0;
  int cell_p = 4;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ir_wake_matcher dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_in(rx_in), .wake(wake)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic expect_reg(input string tag, input logic [3:0] a, input int exp);
    logic [7:0] v;
    rd(a, v);
    check(tag, int'(v), exp);
  endtask

  task automatic load(input logic [87:0] cmp, input logic [87:0] msk);
    wr(4'h8, 8'h10);
    for (int i = 0; i < 11; i++) wr(4'h9, cmp[i*8 +: 8]);
    wr(4'h8, 8'h20);
    for (int i = 0; i < 11; i++) wr(4'h9, msk[i*8 +: 8]);
  endtask

  task automatic send(input logic [87:0] v, input int n, input bit inv);
    @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      rx_in = v[i] ^ inv;
      repeat (cell_p) @(negedge clk);
    end
    rx_in = inv;
    repeat (cell_p * 14) @(negedge clk);
  endtask

  function automatic logic [87:0] manch(input int val, input int nb);
    logic [87:0] r = '0;
    for (int i = nb - 1; i >= 0; i--) r = (r << 2) | (val[i] ? 88'd2 : 88'd1);
    return r;
  endfunction

  function automatic logic [87:0] ones(input int n);
    return (88'd1 << n) - 88'd1;
  endfunction

  task automatic t_reset;
    check("R1 wake", int'(wake), 0);
    expect_reg("R1 ctrl", 4'h3, 0);
    expect_reg("R1 status", 4'h4, 0);
    expect_reg("R1 event enable", 4'h5, 0);
    expect_reg("R1 index", 4'h8, 0);
    expect_reg("R1 data", 4'h9, 0);
    expect_reg("R1 length", 4'hA, 0);
    expect_reg("R1 cell time", 4'hB, 8'h4A);
    expect_reg("R1 spare", 4'hC, 0);
  endtask

  task automatic t_index;
    logic [87:0] c = '0, m = '0;
    for (int i = 0; i < 11; i++) begin
      c[i*8 +: 8] = 8'(i * 17 + 1);
      m[i*8 +: 8] = 8'(8'hF0 - i);
    end
    load(c, m);
    expect_reg("R2 index stops at 11", 4'h8, 8'h2B);
    wr(4'h8, 8'h13);
    expect_reg("R2 compare byte 3", 4'h9, 8'h34);
    expect_reg("R2 read does not advance", 4'h8, 8'h13);
    wr(4'h8, 8'h27);
    expect_reg("R2 mask byte 7", 4'h9, 8'hE9);
    wr(4'h8, 8'h1A);
    wr(4'h9, 8'hAA);
    wr(4'h9, 8'hBB);
    expect_reg("R2 index after overrun", 4'h8, 8'h1B);
    expect_reg("R2 data beyond end", 4'h9, 0);
    wr(4'h8, 8'h1A);
    expect_reg("R2 last byte kept", 4'h9, 8'hAA);
    wr(4'h8, 8'h30);
    expect_reg("R2 invalid select reads 0", 4'h9, 0);
  endtask

  task automatic t_manchester;
    logic [87:0] v = manch(10'h2D5, 10);
    wr(4'hB, 8'd3); cell_p = 4;
    wr(4'hA, 8'd20);
    wr(4'h3, 8'h21);
    load(v, ones(20));
    wr(4'h4, 8'h17);
    send(v, 20, 1'b0);
    expect_reg("R4 R5 R7 manchester match", 4'h4, 8'h03);
    wr(4'h4, 8'h17);
    expect_reg("R10 clear all", 4'h4, 8'h00);
    send(v ^ 88'h20, 20, 1'b0);
    expect_reg("R5 unmasked cell differs", 4'h4, 8'h02);
    wr(4'h4, 8'h17);
    load(v, ones(20) ^ 88'h20);
    send(v ^ 88'h20, 20, 1'b0);
    expect_reg("R5 masked cell ignored", 4'h4, 8'h03);
    wr(4'h4, 8'h17);
  endtask

  task automatic t_protocol;
    logic [87:0] v = 88'h2CBB;
    load(v, ones(14));
    wr(4'h3, 8'h01);
    send(v, 14, 1'b0);
    expect_reg("R4 fixed 14 cells", 4'h4, 8'h03);
    wr(4'h4, 8'h17);
    wr(4'h3, 8'h31);
    send(v, 14, 1'b0);
    expect_reg("R4 protocol 3 no compare", 4'h4, 8'h02);
    wr(4'h4, 8'h17);
    wr(4'h3, 8'h00);
    rx_in = 1'b1;
    wr(4'h3, 8'h09);
    repeat (40) @(negedge clk);
    send(v, 14, 1'b1);
    expect_reg("R6 inverted line", 4'h4, 8'h03);
    wr(4'h3, 8'h00);
    rx_in = 1'b0;
    wr(4'h4, 8'h17);
    wr(4'hB, 8'd5); cell_p = 6;
    wr(4'h3, 8'h01);
    send(v, 14, 1'b0);
    expect_reg("R3 six-clock cells", 4'h4, 8'h03);
    wr(4'h4, 8'h17);
    wr(4'hB, 8'd3); cell_p = 4;
  endtask

  task automatic t_buffer;
    logic [87:0] alt = {44{2'b10}};
    wr(4'hA, 8'd0);
    wr(4'h3, 8'h21);
    @(negedge clk);
    for (int i = 0; i < 90; i++) begin
      rx_in = alt[87 - (i % 88)];
      repeat (cell_p) @(negedge clk);
    end
    rx_in = 1'b0;
    repeat (cell_p * 14) @(negedge clk);
    expect_reg("R8 buffer full", 4'h4, 8'h06);
    wr(4'h4, 8'h17);
  endtask

  task automatic t_nec;
    logic [87:0] v = 88'hB5A3C96D;
    load(v, ones(32));
    wr(4'h3, 8'h11);
    send(88'hF, 4, 1'b0);
    expect_reg("R9 short burst repeat", 4'h4, 8'h12);
    wr(4'h4, 8'h17);
    send(v, 32, 1'b0);
    expect_reg("R9 full message no repeat", 4'h4, 8'h03);
  endtask

  task automatic t_wake;
    logic [7:0] s;
    check("R11 wake with no enable", int'(wake), 0);
    wr(4'h5, 8'h01);
    @(negedge clk); check("R11 match enabled", int'(wake), 1);
    wr(4'h3, 8'h10);
    @(negedge clk); check("R11 receiver off", int'(wake), 0);
    wr(4'h3, 8'h11);
    wr(4'h4, 8'h00);
    expect_reg("R10 zero write keeps", 4'h4, 8'h03);
    wr(4'h4, 8'h02);
    expect_reg("R10 clear one flag", 4'h4, 8'h01);
    wr(4'h5, 8'h02);
    @(negedge clk); check("R11 end flag cleared", int'(wake), 0);
    wr(4'h5, 8'h01);
    wr(4'h4, 8'h01);
    @(negedge clk); check("R11 wake after clear", int'(wake), 0);
    rd(4'h4, s);
    check("R10 status empty", int'(s), 0);
  endtask

  task automatic t_disable;
    wr(4'h3, 8'h10);
    send(88'hB5A3C96D, 32, 1'b0);
    expect_reg("R12 receiver off sets nothing", 4'h4, 8'h00);
    check("R12 wake low", int'(wake), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_index();
    t_manchester();
    t_protocol();
    t_buffer();
    t_nec();
    t_wake();
    t_disable();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule